// File: doc/BRIEF.md
# Byte-Wide Parallel Flash Bridge

This block connects a simplified host memory target port to an external flash or boot ROM that has an 8-bit data bus. A host access to the flash window carries a dword address, four byte enables, a direction and, for a write, a 32-bit data word. The bridge stores the request and runs one flash byte cycle for each enabled lane, lowest lane first. For a read, it assembles the returned bytes into a 32-bit word. Each flash byte cycle takes a programmable number of wait cycles.

Flash accesses are far slower than the host bus, so the host never waits for one. The first request gets a retry response. Any request that arrives while the byte cycles run also gets a retry. Once the byte cycles finish, the next request that matches the stored one completes. Every response, whether acknowledge or retry, also carries a disconnect. So a transaction moves at most one data word, and a host burst cannot continue past its first data phase.

Two more controls apply. A size selector masks off the flash address bits above the installed device, so accesses beyond the device wrap. A write-enable control decides whether host writes reach the flash. Reads are never gated by it.

Top module: `flash_bridge`

## Requirements
- R1: While reset is held and after it is released, flashCeN, flashOeN and flashWeN are high, flashDataOe is low, and neither hostAck nor hostRetry is asserted.
- R2: Each cycle with hostReq high is answered in the following cycle by exactly one of hostAck or hostRetry, with hostStop asserted alongside. No response appears without a request in the previous cycle.
- R3: A request arriving with the bridge idle is stored and answered with retry. Requests that arrive while the byte cycles run are answered with retry. With n flash byte cycles and W wait cycles, back-to-back repeats receive exactly n*(W+3)+1 retries before the acknowledge.
- R4: A read issues one flash read cycle per enabled lane, in ascending lane order. The byte read for lane i appears in hostRdData bits [8i+7:8i], and lanes that are not enabled read as zero.
- R5: The flash address of lane i is the host address with bits [1:0] replaced by i, reduced to 19 bits. It is then masked to the device size: sizeSel values 0, 1, 2 and 3 select 64, 128, 256 and 512 KB, and address bits at or above 16+sizeSel are driven 0.
- R6: In each byte cycle, flashCeN goes low one cycle before the strobe. The strobe (flashOeN for reads, flashWeN for writes) stays low for waitCycles+1 cycles. flashCeN stays low for one cycle after the strobe rises. flashOeN and flashWeN are never low together.
- R7: With flashWrEn high, a write issues one flash write cycle per enabled lane, in ascending lane order. Each cycle drives byte lane i of hostWrData on flashDataOut with flashDataOe high. flashDataOe is low during read cycles.
- R8: A write requested while flashWrEn is low produces no flashWeN pulse, yet completes with an acknowledge on the first matching repeat.
- R9: A repeat that differs from the stored request in address, direction or byte enables is answered with retry and starts no flash cycle. The stored request is kept, and the matching repeat is acknowledged afterwards.
- R10: A request with all byte enables clear runs no flash cycle. It is acknowledged on the first matching repeat, with hostRdData equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | Host access to the flash window this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 24 | Byte address within the window (bits [1:0] ignored) |
| hostByteEn | input | 4 | Byte lane enables, bit i selects bits [8i+7:8i] |
| hostWrData | input | 32 | Write data |
| hostAck | output | 1 | Data phase completed |
| hostRetry | output | 1 | Access not ready, repeat it later |
| hostStop | output | 1 | Disconnect, asserted with every response |
| hostRdData | output | 32 | Assembled read data, valid with hostAck |
| sizeSel | input | 2 | Installed flash size, 64 KB shifted left by sizeSel |
| waitCycles | input | 8 | Extra strobe cycles per flash byte |
| flashWrEn | input | 1 | Flash write enable control |
| flashAddr | output | 19 | Flash byte address |
| flashDataOut | output | 8 | Flash write data |
| flashDataOe | output | 1 | Drive enable for flashDataOut |
| flashDataIn | input | 8 | Flash read data |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |

## Verification
Two things can meet in one cycle: the host repeating its request, and the end of the last byte cycle or the first cycle of the completed state. The bench repeats each request on every clock, so a repeat arrives exactly when the final hold cycle ends. In that cycle the bridge must still answer retry. The acknowledge must come only for the repeat made in the next cycle. The bench judges this by comparing the exact retry count against n*(W+3)+1, for several lane counts and wait settings. It checks stored-request matching against mismatched repeats made once the bridge has finished.

// File: rtl/flash_bridge_pkg.sv
package flash_bridge_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } bridgeState_t;

  // strobes from control to datapath and pins
  typedef struct packed {
    logic              latch;
    logic              capture;
    logic [LANE_W-1:0] lane;
    logic              ceOn;
    logic              oeOn;
    logic              weOn;
    logic              busOn;
  } ctrlStrobe_t;

  function automatic logic [LANE_W-1:0] firstLane(input logic [LANES-1:0] be);
    logic [LANE_W-1:0] idx;
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (be[i]) idx = LANE_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/flash_bridge_ctrl.sv
module flash_bridge_ctrl
  import flash_bridge_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [LANES-1:0]  hostByteEn,
  input  logic              reqMatch,
  input  logic              flashWrEn,
  input  logic [WAIT_W-1:0] waitCycles,
  output ctrlStrobe_t       strobe,
  output logic              respAck,
  output logic              respRetry
);

  bridgeState_t      state;
  logic [LANES-1:0]  remBe;
  logic [LANES-1:0]  remAfter;
  logic [LANE_W-1:0] curLane;
  logic [WAIT_W-1:0] cnt;
  logic              isWrite;
  logic              doneHit;
  logic              inCycle;

  assign doneHit  = (state == ST_DONE) && reqMatch;
  assign remAfter = remBe & ~(LANES'(1) << curLane);
  assign inCycle  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

  always_comb begin
    strobe         = '0;
    strobe.latch   = (state == ST_IDLE) && hostReq;
    strobe.capture = (state == ST_STROBE) && (cnt == '0) && !isWrite;
    strobe.lane    = curLane;
    strobe.ceOn    = inCycle;
    strobe.oeOn    = (state == ST_STROBE) && !isWrite;
    strobe.weOn    = (state == ST_STROBE) && isWrite;
    strobe.busOn   = inCycle && isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remBe     <= '0;
      curLane   <= '0;
      cnt       <= '0;
      isWrite   <= 1'b0;
      respAck   <= 1'b0;
      respRetry <= 1'b0;
    end else begin
      respAck   <= hostReq && doneHit;
      respRetry <= hostReq && !doneHit;
      unique case (state)
        ST_IDLE: begin
          if (hostReq) begin
            isWrite <= hostWrite;
            remBe   <= hostByteEn;
            curLane <= firstLane(hostByteEn);
            if ((hostByteEn == '0) || (hostWrite && !flashWrEn)) state <= ST_DONE;
            else                                                 state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt   <= waitCycles;
          state <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt == '0) state <= ST_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        ST_HOLD: begin
          remBe   <= remAfter;
          curLane <= firstLane(remAfter);
          state   <= (remAfter == '0) ? ST_DONE : ST_SETUP;
        end
        ST_DONE: begin
          if (doneHit) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_bridge_dp.sv
module flash_bridge_dp
  import flash_bridge_pkg::*;
#(
  parameter int HOST_AW  = 24,
  parameter int FLASH_AW = 19,
  parameter int MIN_LOG2 = 16,
  parameter int SIZE_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                hostReq,
  input  logic                hostWrite,
  input  logic [HOST_AW-1:0]  hostAddr,
  input  logic [LANES-1:0]    hostByteEn,
  input  logic [8*LANES-1:0]  hostWrData,
  input  logic [SIZE_W-1:0]   sizeSel,
  input  logic [7:0]          flashDataIn,
  output logic                reqMatch,
  output logic [8*LANES-1:0]  hostRdData,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic [7:0]          flashDataOut
);

  localparam int DW_AW = HOST_AW - LANE_W;

  logic [DW_AW-1:0]    pendAddr;
  logic [LANES-1:0]    pendBe;
  logic                pendWrite;
  logic [8*LANES-1:0]  pendWdata;
  logic [8*LANES-1:0]  pendRdata;
  logic [HOST_AW-1:0]  laneAddr;
  logic [FLASH_AW-1:0] sizeMask;

  for (genvar i = 0; i < FLASH_AW; i++) begin : g_mask
    assign sizeMask[i] = (i < (MIN_LOG2 + int'(sizeSel)));
  end

  assign reqMatch = hostReq && (hostWrite == pendWrite) && (hostByteEn == pendBe)
                 && (hostAddr[HOST_AW-1:LANE_W] == pendAddr);

  assign laneAddr     = {pendAddr, strobe.lane};
  assign flashAddr    = laneAddr[FLASH_AW-1:0] & sizeMask;
  assign flashDataOut = pendWdata[{strobe.lane, 3'b000} +: 8];
  assign hostRdData   = pendRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendBe    <= '0;
      pendWrite <= 1'b0;
      pendWdata <= '0;
      pendRdata <= '0;
    end else if (strobe.latch) begin
      pendAddr  <= hostAddr[HOST_AW-1:LANE_W];
      pendBe    <= hostByteEn;
      pendWrite <= hostWrite;
      pendWdata <= hostWrData;
      pendRdata <= '0;
    end else if (strobe.capture) begin
      pendRdata[{strobe.lane, 3'b000} +: 8] <= flashDataIn;
    end
  end

endmodule

// File: rtl/flash_bridge.sv
module flash_bridge
  import flash_bridge_pkg::*;
#(
  parameter int HOST_AW  = 24,
  parameter int FLASH_AW = 19,
  parameter int MIN_LOG2 = 16,
  parameter int SIZE_W   = 2,
  parameter int WAIT_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReq,
  input  logic                hostWrite,
  input  logic [HOST_AW-1:0]  hostAddr,
  input  logic [LANES-1:0]    hostByteEn,
  input  logic [8*LANES-1:0]  hostWrData,
  output logic                hostAck,
  output logic                hostRetry,
  output logic                hostStop,
  output logic [8*LANES-1:0]  hostRdData,
  input  logic [SIZE_W-1:0]   sizeSel,
  input  logic [WAIT_W-1:0]   waitCycles,
  input  logic                flashWrEn,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic [7:0]          flashDataOut,
  output logic                flashDataOe,
  input  logic [7:0]          flashDataIn,
  output logic                flashCeN,
  output logic                flashOeN,
  output logic                flashWeN
);

  ctrlStrobe_t strobe;
  logic        reqMatch;

  flash_bridge_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .hostWrite  (hostWrite),
    .hostByteEn (hostByteEn),
    .reqMatch   (reqMatch),
    .flashWrEn  (flashWrEn),
    .waitCycles (waitCycles),
    .strobe     (strobe),
    .respAck    (hostAck),
    .respRetry  (hostRetry)
  );

  flash_bridge_dp #(
    .HOST_AW  (HOST_AW),
    .FLASH_AW (FLASH_AW),
    .MIN_LOG2 (MIN_LOG2),
    .SIZE_W   (SIZE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .hostReq      (hostReq),
    .hostWrite    (hostWrite),
    .hostAddr     (hostAddr),
    .hostByteEn   (hostByteEn),
    .hostWrData   (hostWrData),
    .sizeSel      (sizeSel),
    .flashDataIn  (flashDataIn),
    .reqMatch     (reqMatch),
    .hostRdData   (hostRdData),
    .flashAddr    (flashAddr),
    .flashDataOut (flashDataOut)
  );

  assign hostStop    = hostAck | hostRetry;
  assign flashCeN    = ~strobe.ceOn;
  assign flashOeN    = ~strobe.oeOn;
  assign flashWeN    = ~strobe.weOn;
  assign flashDataOe = strobe.busOn;

endmodule

// File: rtl/flash_bridge_chk.sv
module flash_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic hostReq,
  input logic hostAck,
  input logic hostRetry,
  input logic flashCeN,
  input logic flashOeN,
  input logic flashWeN,
  input logic flashDataOe
);

  // R6
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashOeN && !flashWeN));

  // R6
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN || !flashWeN) |-> !flashCeN);

  // R6
  oe_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashOeN) |-> $past(!flashCeN));

  // R6
  we_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> $past(!flashCeN));

  // R2
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostAck && hostRetry));

  // R2
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck || hostRetry) |-> $past(hostReq));

  // R2
  req_answered_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReq |=> (hostAck || hostRetry));

  // R7
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> flashDataOe);

  // R4
  read_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !flashDataOe);

endmodule

bind flash_bridge flash_bridge_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostReq     (hostReq),
  .hostAck     (hostAck),
  .hostRetry   (hostRetry),
  .flashCeN    (flashCeN),
  .flashOeN    (flashOeN),
  .flashWeN    (flashWeN),
  .flashDataOe (flashDataOe)
);

// File: tb/flash_bridge_tb.sv
`timescale 1ns/1ps
module flash_bridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [23:0] hostAddr = '0;
  logic [3:0]  hostByteEn = '0;
  logic [31:0] hostWrData = '0;
  logic        hostAck, hostRetry, hostStop;
  logic [31:0] hostRdData;
  logic [1:0]  sizeSel = 2'd3;
  logic [7:0]  waitCycles = 8'd2;
  logic        flashWrEn = 1'b0;
  logic [18:0] flashAddr;
  logic [7:0]  flashDataOut;
  logic        flashDataOe;
  logic [7:0]  flashDataIn;
  logic        flashCeN, flashOeN, flashWeN;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  flash_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostByteEn(hostByteEn), .hostWrData(hostWrData),
    .hostAck(hostAck), .hostRetry(hostRetry), .hostStop(hostStop),
    .hostRdData(hostRdData), .sizeSel(sizeSel), .waitCycles(waitCycles),
    .flashWrEn(flashWrEn), .flashAddr(flashAddr), .flashDataOut(flashDataOut),
    .flashDataOe(flashDataOe), .flashDataIn(flashDataIn), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN)
  );

  // flash model: content is a function of the address
  function automatic logic [7:0] romByte(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  assign flashDataIn = romByte(flashAddr);

  // pin monitor
  int          rdCnt = 0, wrCnt = 0, oeRun = 0, weRun = 0;
  int          lastOeW = 0, lastWeW = 0, timingErr = 0;
  logic [18:0] rdLog [8];
  logic [18:0] wrLogA [8];
  logic [7:0]  wrLogD [8];
  logic        prevCe = 1'b1, prevOe = 1'b1, prevWe = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (!flashOeN) begin
        if (oeRun == 0) begin
          rdLog[rdCnt % 8] = flashAddr;
          rdCnt++;
          if (prevCe || !prevOe) timingErr++;
        end
        oeRun++;
      end else if (oeRun > 0) begin
        lastOeW = oeRun;
        if (flashCeN) timingErr++;
        oeRun = 0;
      end
      if (!flashWeN) begin
        if (weRun == 0) begin
          wrLogA[wrCnt % 8] = flashAddr;
          wrLogD[wrCnt % 8] = flashDataOut;
          wrCnt++;
          if (prevCe || !prevWe || !flashDataOe) timingErr++;
        end
        weRun++;
      end else if (weRun > 0) begin
        lastWeW = weRun;
        if (flashCeN) timingErr++;
        weRun = 0;
      end
      prevCe = flashCeN;
      prevOe = flashOeN;
      prevWe = flashWeN;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [23:0] a, input logic [3:0] be,
                                          input logic [1:0] sz);
    logic [31:0] r;
    logic [18:0] m;
    logic [18:0] fa;
    r = '0;
    m = (19'h1 << (16 + int'(sz))) - 19'h1;
    for (int i = 0; i < 4; i++) begin
      fa = {a[18:2], 2'(i)} & m;
      if (be[i]) r[8*i +: 8] = romByte(fa);
    end
    return r;
  endfunction

  // issue a request and repeat it every cycle until acknowledged
  task automatic access(input logic wr, input logic [23:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input int nBytes, output logic [31:0] rd);
    int retries = 0;
    int polls = 0;
    bit acked = 0;
    int badResp = 0;
    rd = '0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostByteEn = be; hostWrData = wd;
    while (!acked && polls < 400) begin
      @(negedge clk);
      polls++;
      if ((hostAck == hostRetry) || !hostStop) badResp++;
      if (hostAck) begin
        acked = 1;
        rd = hostRdData;
        hostReq = 1'b0;
      end else begin
        retries++;
      end
    end
    hostReq = 1'b0;
    chk(badResp == 0, "R2", "responses lacking single ack/retry with stop", badResp, 0);
    chk(acked, "R3", "acknowledge received", 32'(acked), 1);
    chk(retries == nBytes * (int'(waitCycles) + 3) + 1, "R3", "retry count",
        retries, nBytes * (int'(waitCycles) + 3) + 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    chk(flashCeN && flashOeN && flashWeN, "R1", "strobes high in reset",
        {flashCeN, flashOeN, flashWeN}, 3'b111);
    chk(!flashDataOe && !hostAck && !hostRetry, "R1", "no drive or response in reset",
        {flashDataOe, hostAck, hostRetry}, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(flashCeN && flashOeN && flashWeN && !hostStop, "R1", "idle after reset",
        {flashCeN, flashOeN, flashWeN, hostStop}, 4'b1110);
  endtask

  task automatic testFullRead();
    logic [31:0] rd;
    int r0;
    sizeSel = 2'd3; waitCycles = 8'd2; r0 = rdCnt;
    access(1'b0, 24'h07_2344, 4'hF, '0, 4, rd);
    chk(rd == expRead(24'h07_2344, 4'hF, 2'd3), "R4", "full read data", rd,
        expRead(24'h07_2344, 4'hF, 2'd3));
    chk(rdCnt - r0 == 4, "R4", "read cycles", rdCnt - r0, 4);
    chk(rdLog[r0 % 8] == 19'h72344 && rdLog[(r0 + 3) % 8] == 19'h72347, "R5",
        "unwrapped lane addresses", rdLog[(r0 + 3) % 8], 19'h72347);
    chk(lastOeW == 3, "R6", "OE width waitCycles+1", lastOeW, 3);
    chk(timingErr == 0, "R6", "setup/hold violations", timingErr, 0);
  endtask

  task automatic testPartialRead();
    logic [31:0] rd;
    int r0;
    waitCycles = 8'd1; r0 = rdCnt;
    access(1'b0, 24'h00_0A10, 4'b1010, '0, 2, rd);
    chk(rd == expRead(24'h00_0A10, 4'b1010, 2'd3), "R4", "partial read, off lanes zero",
        rd, expRead(24'h00_0A10, 4'b1010, 2'd3));
    chk(rdLog[r0 % 8] == 19'h00A11 && rdLog[(r0 + 1) % 8] == 19'h00A13, "R4",
        "ascending lane order", rdLog[r0 % 8], 19'h00A11);
    chk(lastOeW == 2, "R6", "OE width waitCycles+1", lastOeW, 2);
  endtask

  task automatic testWrap();
    logic [31:0] rd;
    int r0;
    sizeSel = 2'd0; waitCycles = 8'd0; r0 = rdCnt;
    access(1'b0, 24'hF7_1230, 4'b0001, '0, 1, rd);
    chk(rdLog[r0 % 8] == 19'h01230, "R5", "64 KB wrap address", rdLog[r0 % 8], 19'h01230);
    chk(rd == {24'h0, romByte(19'h01230)}, "R5", "wrapped read data", rd,
        {24'h0, romByte(19'h01230)});
    sizeSel = 2'd2; r0 = rdCnt;
    access(1'b0, 24'h07_1234, 4'b0100, '0, 1, rd);
    chk(rdLog[r0 % 8] == 19'h31236, "R5", "256 KB wrap address", rdLog[r0 % 8], 19'h31236);
    sizeSel = 2'd3;
  endtask

  task automatic testWrite();
    logic [31:0] rd;
    int w0;
    flashWrEn = 1'b1; waitCycles = 8'd0; w0 = wrCnt;
    access(1'b1, 24'h00_0100, 4'b0110, 32'hAABBCCDD, 2, rd);
    chk(wrCnt - w0 == 2, "R7", "write pulses", wrCnt - w0, 2);
    chk(wrLogA[w0 % 8] == 19'h00101 && wrLogD[w0 % 8] == 8'hCC, "R7", "first write byte",
        {wrLogA[w0 % 8], wrLogD[w0 % 8]}, {19'h00101, 8'hCC});
    chk(wrLogA[(w0 + 1) % 8] == 19'h00102 && wrLogD[(w0 + 1) % 8] == 8'hBB, "R7",
        "second write byte", {wrLogA[(w0 + 1) % 8], wrLogD[(w0 + 1) % 8]},
        {19'h00102, 8'hBB});
    chk(lastWeW == 1, "R6", "WE width waitCycles+1", lastWeW, 1);
  endtask

  task automatic testWriteBlocked();
    logic [31:0] rd;
    int w0;
    flashWrEn = 1'b0; waitCycles = 8'd3; w0 = wrCnt;
    access(1'b1, 24'h00_0200, 4'hF, 32'h11223344, 0, rd);
    chk(wrCnt == w0, "R8", "no write pulse while disabled", wrCnt - w0, 0);
  endtask

  task automatic testMismatch();
    int r0;
    logic ackSeen;
    logic [31:0] rdv;
    waitCycles = 8'd1; r0 = rdCnt;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 24'h00_4000; hostByteEn = 4'hF;
    @(negedge clk); hostReq = 1'b0;
    repeat (4 * 4 + 4) @(negedge clk);
    hostReq = 1'b1; hostAddr = 24'h00_4004;
    @(negedge clk);
    chk(hostRetry && !hostAck, "R9", "different address retried", {hostAck, hostRetry}, 2'b01);
    hostAddr = 24'h00_4000; hostWrite = 1'b1;
    @(negedge clk);
    chk(hostRetry && !hostAck, "R9", "different direction retried", {hostAck, hostRetry}, 2'b01);
    hostWrite = 1'b0; hostByteEn = 4'h3;
    @(negedge clk);
    chk(hostRetry && !hostAck, "R9", "different enables retried", {hostAck, hostRetry}, 2'b01);
    hostByteEn = 4'hF;
    @(negedge clk);
    ackSeen = hostAck; rdv = hostRdData;
    hostReq = 1'b0;
    chk(ackSeen, "R9", "matching repeat acknowledged", 32'(ackSeen), 1);
    chk(rdv == expRead(24'h00_4000, 4'hF, 2'd3), "R9", "stored read data kept", rdv,
        expRead(24'h00_4000, 4'hF, 2'd3));
    repeat (3) @(negedge clk);
    chk(rdCnt - r0 == 4, "R9", "mismatches start no flash cycle", rdCnt - r0, 4);
  endtask

  task automatic testNoLanes();
    logic [31:0] rd;
    int r0, w0;
    r0 = rdCnt; w0 = wrCnt; waitCycles = 8'd2;
    access(1'b0, 24'h00_0800, 4'h0, '0, 0, rd);
    chk(rd == 32'h0, "R10", "empty read data", rd, 0);
    chk(rdCnt == r0 && wrCnt == w0, "R10", "no flash cycles", rdCnt - r0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testFullRead();
    testPartialRead();
    testWrap();
    testWrite();
    testWriteBlocked();
    testMismatch();
    testNoLanes();
    chk(timingErr == 0, "R6", "strobe setup/hold over whole run", timingErr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule